// File: doc/BRIEF.md
# Double-Buffered PWM Compare Pair

This block keeps the two compare thresholds, A and B, that a PWM timer's comparators use. Software writes a new threshold into a staging (shadow) register for a channel. The comparators only ever see the committed (active) copy. Each channel has its own trigger-select field in a configuration register. That field picks when the staged value is committed: at the moment of the write, when the timer wraps to zero, when it reaches its period, or when an external sync pulse arrives. A freeze bit stops all commits.

Each channel shows a hardware-owned pending flag in the configuration register. The flag rises when a value is staged and falls when the active register takes that value. Software uses it to learn whether a new threshold has taken effect yet. The timer itself and the waveform logic sit outside the block. They only supply the three one-cycle event strobes and consume the two active values.

Register map: address 0 is the configuration register, address 1 is the channel A staging register, address 2 is the channel B staging register, and address 3 reads as zero. Writes are single-cycle strobes. Reads are combinational on a separate read address.

Top module: `pwm_cmp_pair`

## Requirements
- R1: After reset the configuration register, both staging registers, both active values and both pending flags read as zero.
- R2: With a channel's trigger field equal to 0, a write to its staging register updates that channel's active value at the same clock edge, and the pending flag stays clear.
- R3: Trigger field bit 0 set: a pending value is committed on the cycle `tmr_zero` is high.
- R4: Trigger field bit 1 set: a pending value is committed on the cycle `tmr_period` is high.
- R5: Trigger field bit 2 set: a pending value is committed on the cycle `tmr_sync` is high.
- R6: Trigger field bit 3 set: no commit happens whatever the other bits and events are, and the active value holds.
- R7: With several of bits 0 to 2 set, any one of the enabled events commits the pending value.
- R8: A staging write under a nonzero trigger field sets the channel's pending flag (configuration bit 8 for A, bit 9 for B). A commit clears it.
- R9: An enabled event with no pending value leaves the active value unchanged and the flag clear.
- R10: When a staging write and an enabled event hit in the same cycle, the active value takes the previous staged value, the new value is staged, and the flag stays set.
- R11: Bus writes to configuration bits 8 and 9 are ignored. Those bits always show the hardware flags.
- R12: Channel A's trigger field is configuration bits 3:0 and channel B's is bits 7:4. Each channel responds only to its own field and its own staging write.
- R13: Reading address 1 or 2 returns the channel's staged value (low 16 bits). Reading address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_waddr | input | 2 | Write address (0 config, 1 stage A, 2 stage B) |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 16 | Combinational read data |
| tmr_zero | input | 1 | Timer-at-zero strobe |
| tmr_period | input | 1 | Timer-at-period strobe |
| tmr_sync | input | 1 | External sync strobe |
| cmp_a | output | 16 | Active compare value A |
| cmp_b | output | 16 | Active compare value B |

## Verification
A staging write and a commit event can land on the same clock edge. In that case the commit must move the old staged value and the write must leave the flag pending. The bench provokes this by asserting `tmr_zero` in the very cycle that a second staging write is strobed. It expects the first value on the active output after that edge and the second value after the next zero event. Commits that arrive while the freeze bit is set or while nothing is pending are judged in the same way, cycle by cycle, against a model held in the bench.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  localparam int NCH       = 2;
  localparam int MW        = 4;
  localparam int FLAG_BASE = NCH * MW;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_STG_A = 2'd1,
    SEL_STG_B = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic sync;
    logic period;
    logic zero;
  } tmr_evt_t;

  // trigger match: freeze bit dominates, otherwise OR of enabled events
  function automatic logic trig_hit(input logic [MW-1:0] m, input tmr_evt_t e);
    return !m[MW-1] && |(m[MW-2:0] & {e.sync, e.period, e.zero});
  endfunction

  function automatic logic trig_direct(input logic [MW-1:0] m);
    return m == '0;
  endfunction
endpackage

// File: rtl/pwm_cmp_cfg.sv
module pwm_cmp_cfg
  import pwm_cmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  output logic [NCH*MW-1:0] methods,
  output logic [NCH-1:0]    stage_wr
);
  localparam int CFG_W = NCH * MW;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_wr;

  assign cfg_wr = we && (waddr == AW'(SEL_CFG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= wdata[CFG_W-1:0];
  end

  assign methods = cfg_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_wr
    assign stage_wr[ch] = we && (waddr == AW'(ch + 1));
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan
  import pwm_cmp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] method,
  input  tmr_evt_t      evt,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] act,
  output logic [DW-1:0] stage,
  output logic          pend,
  output logic          commit
);
  logic hit;
  logic direct_wr;

  assign hit       = trig_hit(method, evt);
  assign direct_wr = wr && trig_direct(method);
  assign commit    = hit && pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= '0;
      stage <= '0;
      pend  <= 1'b0;
    end else if (direct_wr) begin
      act   <= wdata;
      stage <= wdata;
      pend  <= 1'b0;
    end else begin
      if (commit) act <= stage;
      if (wr) begin
        stage <= wdata;
        pend  <= 1'b1;
      end else if (commit) begin
        pend  <= 1'b0;
      end
    end
  end

  AST_DIRECT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    direct_wr |=> (act == $past(wdata)) && !pend); // R2
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    method[MW-1] |=> $stable(act)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !wr) |=> $stable(act)); // R9
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr) |=> !pend && (act == $past(stage))); // R8
  AST_CLASH_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && wr && !trig_direct(method)) |=> pend && (act == $past(stage)) && (stage == $past(wdata))); // R10
endmodule

// File: rtl/pwm_cmp_rdmux.sv
module pwm_cmp_rdmux
  import pwm_cmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic [AW-1:0]     raddr,
  input  logic [NCH*MW-1:0] methods,
  input  logic [NCH-1:0]    pend,
  input  logic [NCH*DW-1:0] stages,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] cfg_view;

  always_comb begin
    cfg_view = '0;
    cfg_view[NCH*MW-1:0] = methods;
    cfg_view[FLAG_BASE +: NCH] = pend;
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      AW'(SEL_CFG):   rdata = cfg_view;
      AW'(SEL_STG_A): rdata = stages[0 +: DW];
      AW'(SEL_STG_B): rdata = stages[DW +: DW];
      default:        rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_cmp_pair.sv
module pwm_cmp_pair
  import pwm_cmp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [AW-1:0] bus_raddr,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_zero,
  input  logic          tmr_period,
  input  logic          tmr_sync,
  output logic [DW-1:0] cmp_a,
  output logic [DW-1:0] cmp_b
);
  logic [NCH*MW-1:0] methods;
  logic [NCH-1:0]    stage_wr;
  logic [NCH-1:0]    pend;
  logic [NCH-1:0]    commit;
  logic [NCH*DW-1:0] acts;
  logic [NCH*DW-1:0] stages;
  tmr_evt_t          evt;

  assign evt = '{sync: tmr_sync, period: tmr_period, zero: tmr_zero};

  pwm_cmp_cfg #(.DW(DW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .waddr(bus_waddr),
    .wdata(bus_wdata), .methods(methods), .stage_wr(stage_wr)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_cmp_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .method(methods[ch*MW +: MW]),
      .evt(evt),
      .wr(stage_wr[ch]),
      .wdata(bus_wdata),
      .act(acts[ch*DW +: DW]),
      .stage(stages[ch*DW +: DW]),
      .pend(pend[ch]),
      .commit(commit[ch])
    );
  end

  pwm_cmp_rdmux #(.DW(DW), .AW(AW)) u_rd (
    .raddr(bus_raddr), .methods(methods), .pend(pend),
    .stages(stages), .rdata(bus_rdata)
  );

  assign cmp_a = acts[0 +: DW];
  assign cmp_b = acts[DW +: DW];

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stage_wr)); // R12
  AST_CFG_FLAGS_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_waddr == AW'(SEL_CFG) && stage_wr == '0) |=> pend == $past(pend & ~commit)); // R11
endmodule

// File: tb/pwm_cmp_pair_bench.sv
module pwm_cmp_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_waddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_raddr = '0;
  logic [15:0] bus_rdata;
  logic        tmr_zero = 1'b0, tmr_period = 1'b0, tmr_sync = 1'b0;
  logic [15:0] cmp_a, cmp_b;

  always #2.5 clk = ~clk;

  pwm_cmp_pair u_pwm_cmp_pair (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .tmr_zero(tmr_zero), .tmr_period(tmr_period), .tmr_sync(tmr_sync),
    .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  typedef struct {
    string       tag;
    logic [15:0] ea;
    logic [15:0] eb;
    logic [15:0] er;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // bench model
  logic [3:0]  m_meth [2];
  logic [15:0] m_stg  [2];
  logic [15:0] m_act  [2];
  bit          m_pend [2];

  function automatic logic [15:0] model_read(input logic [1:0] a);
    if (a == 2'd0) return {6'd0, m_pend[1], m_pend[0], m_meth[1], m_meth[0]};
    if (a == 2'd1) return m_stg[0];
    if (a == 2'd2) return m_stg[1];
    return 16'h0;
  endfunction

  // driver: one cycle of stimulus, pushes the post-edge expectation
  task automatic cyc(input string tag, input bit we, input logic [1:0] wa,
                     input logic [15:0] wd, input bit z, input bit p,
                     input bit s, input logic [1:0] ra);
    exp_t it;
    @(negedge clk);
    bus_we = we; bus_waddr = wa; bus_wdata = wd;
    tmr_zero = z; tmr_period = p; tmr_sync = s; bus_raddr = ra;
    for (int c = 0; c < 2; c++) begin
      bit ev;
      bit w;
      ev = 0;
      if (m_meth[c][3] == 1'b0) begin
        if (m_meth[c][0] && z) ev = 1;
        if (m_meth[c][1] && p) ev = 1;
        if (m_meth[c][2] && s) ev = 1;
      end
      w = we && (wa == 2'(c + 1));
      if (w && m_meth[c] == 4'd0) begin
        m_act[c] = wd; m_stg[c] = wd; m_pend[c] = 0;
      end else begin
        if (ev && m_pend[c]) begin
          m_act[c] = m_stg[c]; m_pend[c] = 0;
        end
        if (w) begin
          m_stg[c] = wd; m_pend[c] = 1;
        end
      end
    end
    if (we && wa == 2'd0) begin
      m_meth[0] = wd[3:0];
      m_meth[1] = wd[7:4];
    end
    it.tag = tag; it.ea = m_act[0]; it.eb = m_act[1]; it.er = model_read(ra);
    q.push_back(it);
  endtask

  task automatic wr(input string tag, input logic [1:0] a, input logic [15:0] d);
    cyc(tag, 1, a, d, 0, 0, 0, 2'd0);
  endtask

  task automatic ev(input string tag, input bit z, input bit p, input bit s);
    cyc(tag, 0, 2'd0, 16'h0, z, p, s, 2'd0);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        n_cmp++;
        if (cmp_a !== it.ea || cmp_b !== it.eb || bus_rdata !== it.er) begin
          n_bad++;
          $display("FAIL %s: actual a=%h b=%h rd=%h expected a=%h b=%h rd=%h",
                   it.tag, cmp_a, cmp_b, bus_rdata, it.ea, it.eb, it.er);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_meth[c] = 0; m_stg[c] = 0; m_act[c] = 0; m_pend[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    cyc("R1 cfg", 0, 0, 0, 0, 0, 0, 2'd0);
    cyc("R1 stage A", 0, 0, 0, 0, 0, 0, 2'd1);
    cyc("R1 stage B", 0, 0, 0, 0, 0, 0, 2'd2);
    // R2 direct copy
    wr("R2 direct A", 2'd1, 16'h1234);
    wr("R2 direct B", 2'd2, 16'hBEEF);
    // R13 readback
    cyc("R13 read A", 0, 0, 0, 0, 0, 0, 2'd1);
    cyc("R13 read B", 0, 0, 0, 0, 0, 0, 2'd2);
    cyc("R13 read none", 0, 0, 0, 0, 0, 0, 2'd3);
    // R3 zero trigger, R8 flag
    wr("R3 cfg", 2'd0, 16'h0001);
    wr("R8 stage A pend", 2'd1, 16'h1111);
    ev("R3 period ignored", 0, 1, 0);
    ev("R3 sync ignored", 0, 0, 1);
    ev("R3 zero commits", 1, 0, 0);
    // R9 no pending
    ev("R9 zero idle", 1, 0, 0);
    // R4 period
    wr("R4 cfg", 2'd0, 16'h0002);
    wr("R4 stage", 2'd1, 16'h2222);
    ev("R4 zero ignored", 1, 0, 0);
    ev("R4 period commits", 0, 1, 0);
    // R5 sync
    wr("R5 cfg", 2'd0, 16'h0004);
    wr("R5 stage", 2'd1, 16'h3333);
    ev("R5 zero+period ignored", 1, 1, 0);
    ev("R5 sync commits", 0, 0, 1);
    // R6 freeze
    wr("R6 cfg", 2'd0, 16'h000F);
    wr("R6 stage", 2'd1, 16'h4444);
    ev("R6 all events frozen", 1, 1, 1);
    ev("R6 zero frozen", 1, 0, 0);
    wr("R6 unfreeze", 2'd0, 16'h0001);
    ev("R6 zero after unfreeze", 1, 0, 0);
    // R7 multiple enables
    wr("R7 cfg", 2'd0, 16'h0003);
    wr("R7 stage1", 2'd1, 16'h5555);
    ev("R7 period commits", 0, 1, 0);
    wr("R7 stage2", 2'd1, 16'h6666);
    ev("R7 zero commits", 1, 0, 0);
    // R10 clash
    wr("R10 cfg", 2'd0, 16'h0001);
    wr("R10 stage X", 2'd1, 16'h7777);
    cyc("R10 write Y with zero", 1, 2'd1, 16'h8888, 1, 0, 0, 2'd0);
    cyc("R10 stage holds Y", 0, 0, 0, 0, 0, 0, 2'd1);
    ev("R10 zero commits Y", 1, 0, 0);
    // R11 flags read-only
    wr("R11 stage pend", 2'd1, 16'h9999);
    wr("R11 cfg clear try", 2'd0, 16'h0001);
    wr("R11 cfg set try", 2'd0, 16'h0321);
    ev("R11 commit", 1, 0, 0);
    wr("R11 cfg set idle", 2'd0, 16'h0301);
    // R12 channel independence
    wr("R12 cfg", 2'd0, 16'h0021);
    wr("R12 stage A", 2'd1, 16'hAAAA);
    wr("R12 stage B", 2'd2, 16'hBBBB);
    ev("R12 zero only A", 1, 0, 0);
    ev("R12 period only B", 0, 1, 0);
    wr("R12 B direct off", 2'd0, 16'h0001);
    wr("R12 B direct", 2'd2, 16'hCCCC);
    ev("R12 settle", 0, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule